// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Idle Timeout

This block turns one asynchronous serial line into characters. A tick input arrives 8 or 16 times per bit period. The receiver times each bit from that tick, takes three samples around the middle of each bit and uses their majority as the bit value. Character length (5 to 9 bits), bit order, parity handling and a multidrop address bit can all be set. Each character is checked for parity and for a valid stop bit.

A finished character is written to a holding register. A one-cycle strobe goes out with it, and a level flag stays high until the consumer acknowledges the read. Error and event flags are sticky; a clear input resets them. A line held low for the whole character is reported as a break, and no character is delivered for it. An idle timer starts after a character completes and raises a flag once when the line has stayed quiet for a programmed number of bit periods. This lets variable-length messages be delimited by idle time.

Top module: `serial_rx_core`

## Requirements
- R1: With `msb_first` = 0, the first data bit received lands in `rx_data[0]`. `char_bits` (5 to 9) sets how many data bits are taken, and the unused upper bits of `rx_data` read 0.
- R2: With `msb_first` = 1, the first data bit received lands in `rx_data[char_bits-1]`.
- R3: `os16_sel` = 1 sets 16 ticks of `os_tick` per bit and `os16_sel` = 0 sets 8. Bit values are the majority of the samples at tick indices half-1, half and half+1 of each bit, where index 0 is the tick that first sees the start low.
- R4: `parity_sel` encoding is 1 = even, 2 = odd, and 0 or 3 = no parity bit. For even parity, the data bits plus the parity bit hold an even number of ones; for odd parity, an odd number. A mismatch sets `err_parity`.
- R5: A low stop-bit sample sets `err_frame`. The character is still delivered.
- R6: If a character is delivered while `rx_full` is set and `rd_ack` is not asserted in that cycle, `err_overrun` is set and the new character replaces the old one.
- R7: If the start bit's mid-bit majority is high, the start is dropped as a glitch. Nothing is delivered, and the next real frame is received normally.
- R8: With `multidrop` = 1, one extra bit after the data is reported on `rx_addr` and parity is not checked. With `multidrop` = 0, `rx_addr` reads 0.
- R9: If every data, parity/address and stop sample is low, the receiver sets `brk_det` and `err_frame`, does not pulse `rx_strobe`, and leaves `rx_data` and `rx_full` unchanged.
- R10: After a character completes, `timeout_flag` is set once `timeout_len` bit periods have passed without a new start bit. Any start bit restarts the count.
- R11: The timeout fires only once per completed character, and `timeout_len` = 0 disables it.
- R12: `rx_strobe` pulses for one cycle for each delivered character. `rx_full` stays high until `rd_ack`. `clr_status` clears all five sticky flags.
- R13: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| os_tick | input | 1 | Oversampling tick, 8 or 16 per bit |
| os16_sel | input | 1 | 1 = 16 ticks per bit, 0 = 8 |
| char_bits | input | 4 | Data bits per character, 5 to 9 |
| parity_sel | input | 2 | 1 even, 2 odd, else none |
| msb_first | input | 1 | Bit order select |
| multidrop | input | 1 | Extra bit is an address flag |
| timeout_len | input | TO_W | Idle bit periods before timeout, 0 = off |
| rx_in | input | 1 | Serial line, idle high |
| rd_ack | input | 1 | Consumer read of the holding register |
| clr_status | input | 1 | Clears the sticky flags |
| rx_data | output | 9 | Received character |
| rx_addr | output | 1 | Address bit of the character |
| rx_strobe | output | 1 | One-cycle pulse on delivery |
| rx_full | output | 1 | Holding register not yet read |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| brk_det | output | 1 | Sticky break seen |
| timeout_flag | output | 1 | Sticky idle timeout |

## Verification
The table walk runs characters at both tick ratios, at lengths 5, 6, 7, 8 and 9, in both bit orders, with no parity, even parity and odd parity, and in multidrop mode. Together these separate shift-direction errors from alignment errors and even-parity from odd-parity mistakes. One flipped parity bit and one low stop bit show that each error flag responds only to its own cause. Directed patterns follow: a short low pulse that must be dropped, two unread characters for overrun, an all-low frame for break, and idle gaps just short of and just past the timeout length.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int CHAR_W = 9;
  localparam int CNT_W  = 4;
  localparam int PH_W   = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_EXTRA, ST_STOP
  } rx_state_e;

  // last tick index within one bit
  function automatic logic [PH_W-1:0] osr_last(input logic os16);
    return os16 ? PH_W'(15) : PH_W'(7);
  endfunction

  // centre tick index within one bit
  function automatic logic [PH_W-1:0] osr_mid(input logic os16);
    return os16 ? PH_W'(8) : PH_W'(4);
  endfunction

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic [CNT_W-1:0] clamp_bits(input logic [CNT_W-1:0] n);
    if (n < CNT_W'(5)) return CNT_W'(5);
    if (n > CNT_W'(CHAR_W)) return CNT_W'(CHAR_W);
    return n;
  endfunction

  function automatic logic parity_on(input logic [1:0] sel);
    return (sel == 2'd1) || (sel == 2'd2);
  endfunction

  function automatic logic [CHAR_W-1:0] shift_in(input logic [CHAR_W-1:0] sh,
                                                 input logic b, input logic msb);
    return msb ? {sh[CHAR_W-2:0], b} : {b, sh[CHAR_W-1:1]};
  endfunction

  // right-align the assembled character
  function automatic logic [CHAR_W-1:0] align_char(input logic [CHAR_W-1:0] sh,
                                                   input logic [CNT_W-1:0] n,
                                                   input logic msb);
    logic [CHAR_W-1:0] mask;
    mask = {CHAR_W{1'b1}} >> (CNT_W'(CHAR_W) - n);
    return msb ? (sh & mask) : (sh >> (CNT_W'(CHAR_W) - n));
  endfunction

  function automatic logic parity_ok(input logic [CHAR_W-1:0] d, input logic pbit,
                                     input logic [1:0] sel);
    case (sel)
      2'd1:    return ((^d) ^ pbit) == 1'b0;
      2'd2:    return ((^d) ^ pbit) == 1'b1;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
  import srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_tick,
  input  logic os16,
  input  logic rx_in,
  input  logic busy,
  output logic start_edge,
  output logic vote_strobe,
  output logic vote_val,
  output logic bit_end
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_s;
  logic                   line_prev;
  logic [PH_W-1:0]        ph;
  logic                   samp_a, samp_b;
  logic [PH_W-1:0]        ph_mid, ph_last;

  assign ph_mid      = osr_mid(os16);
  assign ph_last     = osr_last(os16);
  assign line_s      = sync_q[SYNC_STAGES-1];
  assign start_edge  = os_tick & ~busy & line_prev & ~line_s;
  assign vote_strobe = os_tick & busy & (ph == ph_mid + PH_W'(1));
  assign vote_val    = maj3(samp_a, samp_b, line_s);
  assign bit_end     = os_tick & busy & (ph == ph_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '1;
      line_prev <= 1'b1;
      ph        <= '0;
      samp_a    <= 1'b1;
      samp_b    <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
      if (os_tick) line_prev <= line_s;
      if (start_edge)   ph <= PH_W'(1);
      else if (!busy)   ph <= '0;
      else if (os_tick) ph <= (ph == ph_last) ? '0 : ph + PH_W'(1);
      if (os_tick && busy && ph == ph_mid - PH_W'(1)) samp_a <= line_s;
      if (os_tick && busy && ph == ph_mid)            samp_b <= line_s;
    end
  end

  assert_tick_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vote_strobe |-> !bit_end);
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_edge,
  input  logic              vote_strobe,
  input  logic              vote_val,
  input  logic              bit_end,
  input  logic [CNT_W-1:0]  nbits,
  input  logic [1:0]        psel,
  input  logic              msb,
  input  logic              md,
  output logic              busy,
  output logic              frame_done,
  output logic              glitch,
  output logic [CHAR_W-1:0] char_q,
  output logic              extra_q,
  output logic              stop_q,
  output logic              brk_q
);
  rx_state_e         st;
  logic [CHAR_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  nb_eff;
  logic              seen_high;
  logic              has_extra;

  assign nb_eff    = clamp_bits(nbits);
  assign has_extra = md | parity_on(psel);
  assign busy      = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sh <= '0; cnt <= '0; seen_high <= 1'b0;
      frame_done <= 1'b0; glitch <= 1'b0;
      char_q <= '0; extra_q <= 1'b0; stop_q <= 1'b1; brk_q <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      glitch     <= 1'b0;
      case (st)
        ST_IDLE: if (start_edge) begin
          st <= ST_START; sh <= '0; cnt <= '0; seen_high <= 1'b0; extra_q <= 1'b0;
        end
        ST_START: begin
          if (vote_strobe && vote_val) begin
            st <= ST_IDLE; glitch <= 1'b1;
          end else if (bit_end) st <= ST_DATA;
        end
        ST_DATA: begin
          if (vote_strobe) begin
            sh        <= shift_in(sh, vote_val, msb);
            cnt       <= cnt + CNT_W'(1);
            seen_high <= seen_high | vote_val;
          end
          if (bit_end && cnt == nb_eff) st <= has_extra ? ST_EXTRA : ST_STOP;
        end
        ST_EXTRA: begin
          if (vote_strobe) begin
            extra_q   <= vote_val;
            seen_high <= seen_high | vote_val;
          end
          if (bit_end) st <= ST_STOP;
        end
        ST_STOP: if (vote_strobe) begin
          st         <= ST_IDLE;
          frame_done <= 1'b1;
          stop_q     <= vote_val;
          brk_q      <= ~(seen_high | vote_val);
          char_q     <= align_char(sh, nb_eff, msb);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_done_on_vote_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(vote_strobe));
  assert_glitch_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    glitch |-> !frame_done && !busy);
endmodule

// File: rtl/srx_idle_timer.sv
module srx_idle_timer
  import srx_pkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            os_tick,
  input  logic            os16,
  input  logic            busy,
  input  logic            start_edge,
  input  logic            frame_done,
  input  logic [TO_W-1:0] limit,
  output logic            tmo_pulse
);
  logic [PH_W-1:0] os_cnt;
  logic [TO_W-1:0] bit_cnt;
  logic            armed;
  logic            count_en;
  logic            period_end;

  assign count_en   = armed & ~busy & os_tick & (limit != '0) & ~frame_done & ~start_edge;
  assign period_end = count_en & (os_cnt == osr_last(os16));
  assign tmo_pulse  = period_end & (bit_cnt == limit - TO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_cnt <= '0; bit_cnt <= '0; armed <= 1'b0;
    end else if (frame_done) begin
      os_cnt <= '0; bit_cnt <= '0; armed <= 1'b1;
    end else if (start_edge) begin
      os_cnt <= '0; bit_cnt <= '0;
    end else if (tmo_pulse) begin
      os_cnt <= '0; bit_cnt <= '0; armed <= 1'b0;
    end else if (count_en) begin
      os_cnt <= period_end ? '0 : os_cnt + PH_W'(1);
      if (period_end) bit_cnt <= bit_cnt + TO_W'(1);
    end
  end

  assert_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |=> !armed);
  assert_single_shot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |=> !tmo_pulse);
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int TO_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              os16_sel,
  input  logic [CNT_W-1:0]  char_bits,
  input  logic [1:0]        parity_sel,
  input  logic              msb_first,
  input  logic              multidrop,
  input  logic [TO_W-1:0]   timeout_len,
  input  logic              rx_in,
  input  logic              rd_ack,
  input  logic              clr_status,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_addr,
  output logic              rx_strobe,
  output logic              rx_full,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              brk_det,
  output logic              timeout_flag
);
  logic              busy, start_edge, vote_strobe, vote_val, bit_end;
  logic              frame_done, glitch, extra_q, stop_q, brk_q, tmo_pulse;
  logic [CHAR_W-1:0] char_q;

  srx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .os16(os16_sel), .rx_in(rx_in),
    .busy(busy), .start_edge(start_edge), .vote_strobe(vote_strobe),
    .vote_val(vote_val), .bit_end(bit_end));

  srx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .start_edge(start_edge), .vote_strobe(vote_strobe),
    .vote_val(vote_val), .bit_end(bit_end), .nbits(char_bits), .psel(parity_sel),
    .msb(msb_first), .md(multidrop), .busy(busy), .frame_done(frame_done),
    .glitch(glitch), .char_q(char_q), .extra_q(extra_q), .stop_q(stop_q),
    .brk_q(brk_q));

  srx_idle_timer #(.TO_W(TO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .os16(os16_sel), .busy(busy),
    .start_edge(start_edge), .frame_done(frame_done), .limit(timeout_len),
    .tmo_pulse(tmo_pulse));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; rx_addr <= 1'b0; rx_strobe <= 1'b0; rx_full <= 1'b0;
      err_parity <= 1'b0; err_frame <= 1'b0; err_overrun <= 1'b0;
      brk_det <= 1'b0; timeout_flag <= 1'b0;
    end else begin
      rx_strobe <= 1'b0;
      if (rd_ack) rx_full <= 1'b0;
      if (clr_status) begin
        err_parity <= 1'b0; err_frame <= 1'b0; err_overrun <= 1'b0;
        brk_det <= 1'b0; timeout_flag <= 1'b0;
      end
      if (tmo_pulse) timeout_flag <= 1'b1;
      if (frame_done) begin
        if (brk_q) begin
          brk_det   <= 1'b1;
          err_frame <= 1'b1;
        end else begin
          rx_data   <= char_q;
          rx_addr   <= multidrop & extra_q;
          rx_strobe <= 1'b1;
          rx_full   <= 1'b1;
          if (!stop_q) err_frame <= 1'b1;
          if (!multidrop && !parity_ok(char_q, extra_q, parity_sel)) err_parity <= 1'b1;
          if (rx_full && !rd_ack) err_overrun <= 1'b1;
        end
      end
    end
  end

  assert_strobe_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> !rx_strobe);
  assert_full_with_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> rx_full);
  assert_overrun_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(rx_full));
  assert_break_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_det) |-> !rx_strobe);
  assert_md_no_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (multidrop && $past(multidrop)) |-> !$rose(err_parity));
  assert_glitch_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    glitch |=> !rx_strobe);
endmodule

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       os16_sel = 1'b1;
  logic [3:0] char_bits = 4'd8;
  logic [1:0] parity_sel = 2'd0;
  logic       msb_first = 1'b0;
  logic       multidrop = 1'b0;
  logic [7:0] timeout_len = 8'd0;
  logic       rx_in = 1'b1;
  logic       rd_ack = 1'b0;
  logic       clr_status = 1'b0;
  logic [8:0] rx_data;
  logic       rx_addr, rx_strobe, rx_full, err_parity, err_frame, err_overrun;
  logic       brk_det, timeout_flag;

  int n_chk = 0;
  int n_fail = 0;
  int n_strobe;

  always #2.5 clk = ~clk;

  serial_rx_core u_dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .os16_sel(os16_sel),
    .char_bits(char_bits), .parity_sel(parity_sel), .msb_first(msb_first),
    .multidrop(multidrop), .timeout_len(timeout_len), .rx_in(rx_in),
    .rd_ack(rd_ack), .clr_status(clr_status), .rx_data(rx_data), .rx_addr(rx_addr),
    .rx_strobe(rx_strobe), .rx_full(rx_full), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun), .brk_det(brk_det),
    .timeout_flag(timeout_flag));

  always_ff @(posedge clk) begin
    if (!rst_n) n_strobe <= 0;
    else if (rx_strobe) n_strobe <= n_strobe + 1;
  end

  // tick once every four clocks
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  // {os16, bits, parity, msb, multidrop, payload, flip/addr, stop}
  localparam logic [19:0] VEC [8] = '{
    {1'b1, 4'd8, 2'd0, 1'b0, 1'b0, 9'h0A5, 1'b0, 1'b1},
    {1'b1, 4'd8, 2'd1, 1'b0, 1'b0, 9'h0F3, 1'b0, 1'b1},
    {1'b1, 4'd7, 2'd2, 1'b1, 1'b0, 9'h05B, 1'b0, 1'b1},
    {1'b0, 4'd5, 2'd0, 1'b0, 1'b0, 9'h016, 1'b0, 1'b1},
    {1'b0, 4'd9, 2'd1, 1'b1, 1'b0, 9'h1C3, 1'b1, 1'b1},
    {1'b1, 4'd8, 2'd0, 1'b0, 1'b0, 9'h081, 1'b0, 1'b0},
    {1'b0, 4'd6, 2'd2, 1'b0, 1'b1, 9'h02D, 1'b1, 1'b1},
    {1'b1, 4'd9, 2'd1, 1'b1, 1'b1, 9'h155, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wait_bits(input int n);
    repeat (n * (os16_sel ? 16 : 8) * 4) @(negedge clk);
  endtask

  task automatic send_bit(input logic v);
    rx_in = v;
    wait_bits(1);
  endtask

  task automatic send_frame(input logic [8:0] pay, input int nb, input logic [1:0] pm,
                            input logic ms, input logic mdv, input logic xbit,
                            input logic stopv);
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) send_bit(ms ? pay[nb-1-i] : pay[i]);
    if (mdv || pm == 2'd1 || pm == 2'd2) send_bit(xbit);
    send_bit(stopv);
    send_bit(1'b1);
  endtask

  task automatic pulse_ack();
    @(negedge clk); rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_status = 1'b1; @(negedge clk); clr_status = 1'b0;
  endtask

  function automatic logic [8:0] mask_n(input int nb);
    return 9'h1FF >> (9 - nb);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    finish_run();
  end

  initial begin
    int s0;
    repeat (4) @(negedge clk);
    // R13 reset state
    chk("R13 data", rx_data, 0);
    chk("R13 flags", {rx_addr, rx_strobe, rx_full, err_parity, err_frame,
                      err_overrun, brk_det, timeout_flag}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: R1 R2 R3 R4 R5 R8 R12
    foreach (VEC[k]) begin
      logic [19:0] v;
      logic [8:0] pay, expd;
      logic pbit, xb, exp_perr;
      int nb;
      v = VEC[k];
      os16_sel = v[19]; char_bits = v[18:15]; parity_sel = v[14:13];
      msb_first = v[12]; multidrop = v[11];
      nb = int'(v[18:15]);
      pay = v[10:2];
      expd = pay & mask_n(nb);
      pbit = (v[14:13] == 2'd1) ? (^expd) : ~(^expd);
      xb = v[11] ? v[1] : (pbit ^ v[1]);
      exp_perr = !v[11] && (v[14:13] == 2'd1 || v[14:13] == 2'd2) && v[1];
      pulse_ack(); pulse_clr();
      s0 = n_strobe;
      send_frame(pay, nb, v[14:13], v[12], v[11], xb, v[0]);
      chk($sformatf("R1 R2 R3 vec%0d data", k), rx_data, expd);
      chk($sformatf("R8 vec%0d addr", k), rx_addr, v[11] ? v[1] : 1'b0);
      chk($sformatf("R4 vec%0d parity err", k), err_parity, exp_perr);
      chk($sformatf("R5 vec%0d frame err", k), err_frame, !v[0]);
      chk($sformatf("R12 vec%0d strobes", k), n_strobe - s0, 1);
    end

    // R7 glitch rejection at 16x
    os16_sel = 1'b1; char_bits = 4'd8; parity_sel = 2'd0; msb_first = 1'b0; multidrop = 1'b0;
    pulse_ack(); pulse_clr();
    s0 = n_strobe;
    rx_in = 1'b0; repeat (12) @(negedge clk); rx_in = 1'b1;
    wait_bits(2);
    chk("R7 glitch no strobe", n_strobe - s0, 0);
    chk("R7 glitch no full", rx_full, 0);
    send_frame(9'h03C, 8, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7 frame after glitch", rx_data, 9'h03C);

    // R6 overrun: rx_full still set from previous frame
    pulse_clr();
    send_frame(9'h0E1, 8, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 overrun set", err_overrun, 1);
    chk("R6 newest kept", rx_data, 9'h0E1);
    pulse_ack();
    chk("R12 full cleared by ack", rx_full, 0);
    pulse_clr();
    send_frame(9'h07E, 8, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R6 no overrun after ack", err_overrun, 0);

    // R9 break
    pulse_ack(); pulse_clr();
    s0 = n_strobe;
    parity_sel = 2'd2;
    send_frame(9'h000, 8, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 break flag", brk_det, 1);
    chk("R9 break frame err", err_frame, 1);
    chk("R9 break no strobe", n_strobe - s0, 0);
    chk("R9 break not loaded", {rx_full, rx_data}, {1'b0, 9'h07E});
    pulse_clr();
    chk("R12 clear all", {err_parity, err_frame, err_overrun, brk_det, timeout_flag}, 0);

    // R10 R11 timeout at 8x
    os16_sel = 1'b0; parity_sel = 2'd0; timeout_len = 8'd4;
    send_frame(9'h055, 8, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    wait_bits(2);
    chk("R10 not early", timeout_flag, 0);
    wait_bits(1);
    chk("R10 fires", timeout_flag, 1);
    pulse_clr();
    wait_bits(6);
    chk("R11 fires once", timeout_flag, 0);
    timeout_len = 8'd0;
    send_frame(9'h055, 8, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    wait_bits(10);
    chk("R11 zero disables", timeout_flag, 0);

    finish_run();
  end
endmodule